// File: doc/BRIEF.md
# Robin Hood Hashed LRU Vector Cache

This block is a small key/value cache for embedding vectors. Keys are placed in an open-addressed hash table. On a collision, Robin Hood displacement lets a newcomer that has travelled further from its home slot take the place of a resident that is closer to its own home. The displaced resident then continues probing, which keeps probe chains short. Recency is tracked in a circular doubly-linked list over a pool of entry nodes. The list head is the most recently used entry, and the node just before the head is the least recently used one.

A client issues one command at a time on a valid/ready interface. A lookup returns hit or miss and, on a hit, the stored value. An insert either overwrites the value of a resident key or adds a new key. When every slot is occupied, a new key first evicts the least recently used entry. Removal from the table uses backward-shift deletion: entries after the hole move back one slot and their probe distance drops by one. Fetching vectors that missed is left to the surrounding system.

Top module: `rh_lru_cache`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` is 0 and the cache is empty, so a lookup of any key misses.
- R2: A lookup (`req_op_i`=0) of a resident key returns `rsp_hit_o`=1 and its value on `rsp_val_o`. A lookup of an absent key returns `rsp_hit_o`=0 and `rsp_val_o`=0, and changes neither contents nor recency.
- R3: An insert (`req_op_i`=1) of a resident key overwrites its value and answers `rsp_hit_o`=1 and `rsp_evict_o`=0. The occupancy does not change.
- R4: The home slot of a key is its low log2(SLOTS) bits. Up to SLOTS keys sharing any home slots are all stored and all retrievable.
- R5: An insert of a new key into a full cache evicts the least recently used entry. It answers `rsp_evict_o`=1 with that entry's key on `rsp_evict_key_o`. A new-key insert into a cache that is not full answers `rsp_evict_o`=0.
- R6: A lookup hit makes that entry the most recently used.
- R7: An insert, whether of a new key or over a resident one, makes that entry the most recently used.
- R8: After evictions, every remaining key is still found with its latest value, and every evicted key misses.
- R9: From acceptance until its response, `req_ready_o` stays 0. `rsp_valid_o` is a one-cycle pulse, and `req_ready_o` is 1 in that same cycle.
- R10: A lookup whose home slot is empty answers with `rsp_valid_o` high two clock edges after the acceptance edge is reached, counting the acceptance edge as the first.
- R11: A lookup of an absent key in a full table terminates and misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command valid |
| req_ready_o | output | 1 | Cache idle and able to accept a command |
| req_op_i | input | 1 | 0 = lookup, 1 = insert |
| req_key_i | input | KEY_W | Command key |
| req_val_i | input | VAL_W | Value to store on insert |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_hit_o | output | 1 | Key was resident |
| rsp_val_o | output | VAL_W | Value on lookup hit, else 0 |
| rsp_evict_o | output | 1 | Insert evicted an entry |
| rsp_evict_key_o | output | KEY_W | Key of the evicted entry |

## Verification
Latency depends on the data. A command spends one cycle per probed slot, one or two cycles reordering the list on a hit, and cycles for the deletion search, backward shift and placement when it evicts. Only the empty-home lookup has a fixed latency of two edges, and the bench measures that case exactly. For every other command, the bench drives the request between edges and then samples the outputs mid-cycle after each edge until the response pulse appears. In each of those cycles it confirms that ready is low, in the pulse cycle it confirms that ready is high, and it reads the results in the pulse cycle itself. One cycle later it confirms that the pulse has dropped.

// File: rtl/rh_cache_pkg.sv
package rh_cache_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PROBE, S_TOUCH, S_LINK, S_DFIND, S_DSHIFT, S_PLACE
  } state_e;

  typedef enum logic [2:0] {
    L_NONE, L_FIRST, L_ROTATE, L_UNLINK, L_LINK
  } list_op_e;

  localparam logic OP_LOOKUP = 1'b0;
  localparam logic OP_INSERT = 1'b1;
endpackage

// File: rtl/rh_slot_table.sv
module rh_slot_table #(
  parameter int SLOTS = 16,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [IDX_W-1:0] rd_node_o,
  output logic [IDX_W-1:0] rd_dist_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [IDX_W-1:0] wr_node_i,
  input  logic [IDX_W-1:0] wr_dist_i,
  output logic [SLOTS-1:0] valid_vec_o
);
  logic [IDX_W-1:0] node_q [SLOTS];
  logic [IDX_W-1:0] dist_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_vec_o[g] <= 1'b0;
        node_q[g]      <= '0;
        dist_q[g]      <= '0;
      end else if (we_i && wr_idx_i == IDX_W'(g)) begin
        valid_vec_o[g] <= wr_valid_i;
        node_q[g]      <= wr_node_i;
        dist_q[g]      <= wr_dist_i;
      end
    end
  end

  assign rd_valid_o = valid_vec_o[rd_idx_i];
  assign rd_node_o  = node_q[rd_idx_i];
  assign rd_dist_o  = dist_q[rd_idx_i];
endmodule

// File: rtl/rh_entry_store.sv
module rh_entry_store #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N),
  parameter int KEY_W = 16,
  parameter int VAL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic [VAL_W-1:0] wr_val_i,
  input  logic [IDX_W-1:0] a_idx_i,
  output logic [KEY_W-1:0] a_key_o,
  output logic [VAL_W-1:0] a_val_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic [KEY_W-1:0] b_key_o
);
  logic [KEY_W-1:0] key_q [N];
  logic [VAL_W-1:0] val_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_q[g] <= '0;
        val_q[g] <= '0;
      end else if (we_i && wr_idx_i == IDX_W'(g)) begin
        key_q[g] <= wr_key_i;
        val_q[g] <= wr_val_i;
      end
    end
  end

  assign a_key_o = key_q[a_idx_i];
  assign a_val_o = val_q[a_idx_i];
  assign b_key_o = key_q[b_idx_i];
endmodule

// File: rtl/rh_lru_list.sv
module rh_lru_list
  import rh_cache_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  list_op_e         op_i,
  input  logic [IDX_W-1:0] node_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o
);
  logic [IDX_W-1:0] prev_q [N];
  logic [IDX_W-1:0] next_q [N];
  logic [IDX_W-1:0] head_q;

  assign head_o = head_q;
  assign tail_o = prev_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      for (int i = 0; i < N; i++) begin
        prev_q[i] <= '0;
        next_q[i] <= '0;
      end
    end else begin
      case (op_i)
        L_FIRST: begin
          prev_q[node_i] <= node_i;
          next_q[node_i] <= node_i;
          head_q         <= node_i;
        end
        L_ROTATE: head_q <= node_i;
        L_UNLINK: begin
          next_q[prev_q[node_i]] <= next_q[node_i];
          prev_q[next_q[node_i]] <= prev_q[node_i];
        end
        L_LINK: begin
          next_q[tail_o] <= node_i;
          prev_q[node_i] <= tail_o;
          next_q[node_i] <= head_q;
          prev_q[head_q] <= node_i;
          head_q         <= node_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rh_lru_cache.sv
module rh_lru_cache
  import rh_cache_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int KEY_W = 16,
  parameter int VAL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_op_i,
  input  logic [KEY_W-1:0] req_key_i,
  input  logic [VAL_W-1:0] req_val_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [VAL_W-1:0] rsp_val_o,
  output logic             rsp_evict_o,
  output logic [KEY_W-1:0] rsp_evict_key_o
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SLOTS);

  state_e           state_q, state_d;
  logic             op_q, op_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic [VAL_W-1:0] val_q, val_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [IDX_W-1:0] dist_q, dist_d;
  logic [IDX_W-1:0] node_q, node_d;
  logic [IDX_W-1:0] steps_q, steps_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             hit_q, hit_d;
  logic [VAL_W-1:0] hold_q, hold_d;
  logic             evict_q, evict_d;
  logic [KEY_W-1:0] evkey_q, evkey_d;
  logic             fin;

  logic             rd_valid;
  logic [IDX_W-1:0] rd_idx, rd_node, rd_dist;
  logic             sl_we, sl_wvalid;
  logic [IDX_W-1:0] sl_widx, sl_wnode, sl_wdist;
  logic [SLOTS-1:0] slot_valid;

  logic             es_we;
  logic [IDX_W-1:0] es_widx;
  logic [KEY_W-1:0] a_key, b_key;
  logic [VAL_W-1:0] a_val;

  list_op_e         lop;
  logic [IDX_W-1:0] lnode, head, tail;

  function automatic logic [IDX_W-1:0] home_f(input logic [KEY_W-1:0] k);
    return k[IDX_W-1:0];
  endfunction

  assign rd_idx = (state_q == S_DSHIFT) ? cur_q + IDX_W'(1) : cur_q;

  rh_slot_table #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_slots (
    .clk_i, .rst_ni,
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_node_o(rd_node), .rd_dist_o(rd_dist),
    .we_i(sl_we), .wr_idx_i(sl_widx), .wr_valid_i(sl_wvalid),
    .wr_node_i(sl_wnode), .wr_dist_i(sl_wdist), .valid_vec_o(slot_valid)
  );

  rh_entry_store #(.N(SLOTS), .IDX_W(IDX_W), .KEY_W(KEY_W), .VAL_W(VAL_W)) u_ents (
    .clk_i, .rst_ni,
    .we_i(es_we), .wr_idx_i(es_widx), .wr_key_i(key_q), .wr_val_i(val_q),
    .a_idx_i(rd_node), .a_key_o(a_key), .a_val_o(a_val),
    .b_idx_i(tail), .b_key_o(b_key)
  );

  rh_lru_list #(.N(SLOTS), .IDX_W(IDX_W)) u_list (
    .clk_i, .rst_ni, .op_i(lop), .node_i(lnode), .head_o(head), .tail_o(tail)
  );

  assign req_ready_o = (state_q == S_IDLE);

  always_comb begin
    state_d = state_q; op_d = op_q; key_d = key_q; val_d = val_q;
    cur_d = cur_q; dist_d = dist_q; node_d = node_q; steps_d = steps_q;
    count_d = count_q; hit_d = hit_q; hold_d = hold_q;
    evict_d = evict_q; evkey_d = evkey_q;
    fin = 1'b0;
    sl_we = 1'b0; sl_widx = cur_q; sl_wvalid = 1'b0; sl_wnode = '0; sl_wdist = '0;
    es_we = 1'b0; es_widx = node_q;
    lop = L_NONE; lnode = node_q;
    unique case (state_q)
      S_IDLE: if (req_valid_i) begin
        op_d = req_op_i; key_d = req_key_i; val_d = req_val_i;
        cur_d = home_f(req_key_i); dist_d = '0; steps_d = '0;
        hit_d = 1'b0; hold_d = '0; evict_d = 1'b0; evkey_d = '0;
        state_d = S_PROBE;
      end
      S_PROBE: begin
        if (rd_valid && a_key == key_q) begin
          hit_d = 1'b1; node_d = rd_node;
          if (op_q == OP_INSERT) begin
            es_we = 1'b1; es_widx = rd_node;
          end else begin
            hold_d = a_val;
          end
          state_d = S_TOUCH;
        end else if (!rd_valid || rd_dist < dist_q || dist_q == IDX_MAX) begin
          if (op_q == OP_LOOKUP) begin
            fin = 1'b1;
          end else if (count_q == CNT_FULL) begin
            node_d = tail; evict_d = 1'b1; evkey_d = b_key;
            cur_d = home_f(b_key);
            state_d = S_DFIND;
          end else begin
            node_d = count_q[IDX_W-1:0];
            es_we = 1'b1; es_widx = count_q[IDX_W-1:0];
            lop = (count_q == '0) ? L_FIRST : L_LINK;
            lnode = count_q[IDX_W-1:0];
            count_d = count_q + CNT_W'(1);
            cur_d = home_f(key_q); dist_d = '0;
            state_d = S_PLACE;
          end
        end else begin
          cur_d = cur_q + IDX_W'(1); dist_d = dist_q + IDX_W'(1);
        end
      end
      S_TOUCH: begin
        if (node_q == head) begin
          fin = 1'b1;
        end else if (node_q == tail) begin
          lop = L_ROTATE; fin = 1'b1;
        end else begin
          lop = L_UNLINK; state_d = S_LINK;
        end
      end
      S_LINK: begin
        lop = L_LINK; fin = 1'b1;
      end
      S_DFIND: begin
        if (rd_valid && rd_node == node_q) begin
          steps_d = '0; state_d = S_DSHIFT;
        end else begin
          cur_d = cur_q + IDX_W'(1);
        end
      end
      S_DSHIFT: begin
        sl_we = 1'b1; sl_widx = cur_q;
        if (rd_valid && rd_dist != '0 && steps_q != IDX_MAX) begin
          sl_wvalid = 1'b1; sl_wnode = rd_node; sl_wdist = rd_dist - IDX_W'(1);
          cur_d = cur_q + IDX_W'(1); steps_d = steps_q + IDX_W'(1);
        end else begin
          es_we = 1'b1; es_widx = node_q;
          lop = L_ROTATE; lnode = node_q;
          cur_d = home_f(key_q); dist_d = '0;
          state_d = S_PLACE;
        end
      end
      S_PLACE: begin
        if (!rd_valid) begin
          sl_we = 1'b1; sl_wvalid = 1'b1; sl_wnode = node_q; sl_wdist = dist_q;
          fin = 1'b1;
        end else if (rd_dist < dist_q) begin
          sl_we = 1'b1; sl_wvalid = 1'b1; sl_wnode = node_q; sl_wdist = dist_q;
          node_d = rd_node; dist_d = rd_dist + IDX_W'(1);
          cur_d = cur_q + IDX_W'(1);
        end else begin
          cur_d = cur_q + IDX_W'(1); dist_d = dist_q + IDX_W'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; op_q <= 1'b0; key_q <= '0; val_q <= '0;
      cur_q <= '0; dist_q <= '0; node_q <= '0; steps_q <= '0; count_q <= '0;
      hit_q <= 1'b0; hold_q <= '0; evict_q <= 1'b0; evkey_q <= '0;
      rsp_valid_o <= 1'b0; rsp_hit_o <= 1'b0; rsp_val_o <= '0;
      rsp_evict_o <= 1'b0; rsp_evict_key_o <= '0;
    end else begin
      state_q <= state_d; op_q <= op_d; key_q <= key_d; val_q <= val_d;
      cur_q <= cur_d; dist_q <= dist_d; node_q <= node_d; steps_q <= steps_d;
      count_q <= count_d; hit_q <= hit_d; hold_q <= hold_d;
      evict_q <= evict_d; evkey_q <= evkey_d;
      rsp_valid_o <= fin;
      if (fin) begin
        rsp_hit_o       <= hit_q;
        rsp_val_o       <= hold_q;
        rsp_evict_o     <= evict_q;
        rsp_evict_key_o <= evkey_q;
      end
    end
  end
endmodule

// File: rtl/rh_lru_cache_chk.sv
module rh_lru_cache_chk #(
  parameter int SLOTS = 16,
  parameter int CNT_W = $clog2(SLOTS) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_evict_o,
  input logic [SLOTS-1:0] slot_valid,
  input logic [CNT_W-1:0] count_q
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else if (req_valid_i && req_ready_o) busy_q <= 1'b1;
    else if (rsp_valid_o) busy_q <= 1'b0;
  end

  AST_RSP_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o); // R9
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R9
  AST_BUSY_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rsp_valid_o) |-> !req_ready_o); // R9
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> busy_q); // R9
  AST_OCC_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> ($countones(slot_valid) == int'(count_q))); // R4
  AST_EVICT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_evict_o) |-> (int'(count_q) == SLOTS)); // R5
endmodule

bind rh_lru_cache rh_lru_cache_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .rsp_evict_o(rsp_evict_o), .slot_valid(slot_valid), .count_q(count_q)
);

// File: tb/sim_rh_lru_cache.sv
module sim_rh_lru_cache;
  localparam int KEY_W = 16;
  localparam int VAL_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_op = 1'b0;
  logic [KEY_W-1:0] req_key = '0;
  logic [VAL_W-1:0] req_val = '0;
  logic             rsp_valid, rsp_hit, rsp_evict;
  logic [VAL_W-1:0] rsp_val;
  logic [KEY_W-1:0] rsp_evkey;

  int checks = 0;
  int errors = 0;

  logic             r_hit, r_evict;
  logic [VAL_W-1:0] r_val;
  logic [KEY_W-1:0] r_evkey;
  int               r_lat;

  always #10 clk = ~clk;

  rh_lru_cache u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_key_i(req_key), .req_val_i(req_val),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_val_o(rsp_val),
    .rsp_evict_o(rsp_evict), .rsp_evict_key_o(rsp_evkey)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_cmd(input logic op, input logic [KEY_W-1:0] k, input logic [VAL_W-1:0] v);
    bit stall_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_key = k; req_val = v;
    @(posedge clk); #5;
    req_valid = 1'b0;
    r_lat = 1;
    while (!rsp_valid && r_lat < 300) begin
      if (req_ready) stall_bad = 1;
      @(posedge clk); #5;
      r_lat++;
    end
    r_hit = rsp_hit; r_val = rsp_val; r_evict = rsp_evict; r_evkey = rsp_evkey;
    chk(rsp_valid && !stall_bad && req_ready, "R9 handshake", {stall_bad, req_ready}, 2'b01);
    @(posedge clk); #5;
    chk(!rsp_valid, "R9 pulse", rsp_valid, 0);
  endtask

  function automatic logic [KEY_W-1:0] kf(input int i);
    return KEY_W'((i << 8) | (i % 4));
  endfunction

  task automatic t_reset_state();
    #5;
    chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", rsp_valid, 0);
    do_cmd(1'b0, 16'h0005, '0);
    chk(!r_hit, "R1 empty miss", r_hit, 0);
  endtask

  task automatic t_latency();
    do_cmd(1'b0, 16'h0003, '0);
    chk(r_lat == 2, "R10 latency", r_lat, 2);
    chk(!r_hit && r_val == 0, "R2 miss value", r_val, 0);
  endtask

  task automatic t_basic();
    do_cmd(1'b1, 16'h0012, 32'hCAFE0001);
    chk(!r_hit && !r_evict, "R5 no evict when not full", r_evict, 0);
    do_cmd(1'b0, 16'h0012, '0);
    chk(r_hit && r_val == 32'hCAFE0001, "R2 hit value", r_val, 32'hCAFE0001);
    do_cmd(1'b0, 16'h0022, '0);
    chk(!r_hit && r_val == 0, "R2 absent same home", r_hit, 0);
  endtask

  task automatic t_collide();
    do_cmd(1'b1, 16'h0105, 32'h105);
    do_cmd(1'b1, 16'h0205, 32'h205);
    do_cmd(1'b1, 16'h0006, 32'h006);
    do_cmd(1'b1, 16'h0305, 32'h305);
    do_cmd(1'b0, 16'h0105, '0);
    chk(r_hit && r_val == 32'h105, "R4 collide 0105", r_val, 32'h105);
    do_cmd(1'b0, 16'h0205, '0);
    chk(r_hit && r_val == 32'h205, "R4 collide 0205", r_val, 32'h205);
    do_cmd(1'b0, 16'h0305, '0);
    chk(r_hit && r_val == 32'h305, "R4 collide 0305", r_val, 32'h305);
    do_cmd(1'b0, 16'h0006, '0);
    chk(r_hit && r_val == 32'h006, "R4 displaced 0006", r_val, 32'h006);
  endtask

  task automatic t_update();
    do_cmd(1'b1, 16'h0205, 32'h9999);
    chk(r_hit && !r_evict, "R3 update reports hit", {r_hit, r_evict}, 2'b10);
    do_cmd(1'b0, 16'h0205, '0);
    chk(r_hit && r_val == 32'h9999, "R3 new value", r_val, 32'h9999);
  endtask

  task automatic t_evict();
    do_reset();
    for (int i = 0; i < 16; i++) begin
      do_cmd(1'b1, kf(i), 32'h1000 + i);
      chk(!r_hit && !r_evict, "R5 fill no evict", r_evict, 0);
    end
    for (int i = 0; i < 16; i++) begin
      do_cmd(1'b0, kf(i), '0);
      chk(r_hit && r_val == 32'h1000 + i, "R4 full table hit", r_val, 32'h1000 + i);
    end
    do_cmd(1'b0, 16'h7F01, '0);
    chk(!r_hit, "R11 full table miss", r_hit, 0);
    do_cmd(1'b1, 16'hAA02, 32'hAA);
    chk(r_evict && r_evkey == kf(0), "R5 evict LRU", r_evkey, kf(0));
    do_cmd(1'b0, kf(1), '0);
    do_cmd(1'b1, 16'hBB03, 32'hBB);
    chk(r_evict && r_evkey == kf(2), "R6 hit refreshes", r_evkey, kf(2));
    do_cmd(1'b1, kf(3), 32'h3333);
    chk(r_hit && !r_evict, "R7 update no evict", {r_hit, r_evict}, 2'b10);
    do_cmd(1'b1, 16'hCC00, 32'hCC);
    chk(r_evict && r_evkey == kf(4), "R7 insert refreshes", r_evkey, kf(4));
    for (int i = 0; i < 16; i++) begin
      do_cmd(1'b0, kf(i), '0);
      if (i == 0 || i == 2 || i == 4)
        chk(!r_hit, "R8 evicted misses", r_hit, 0);
      else if (i == 3)
        chk(r_hit && r_val == 32'h3333, "R8 updated kept", r_val, 32'h3333);
      else
        chk(r_hit && r_val == 32'h1000 + i, "R8 survivor", r_val, 32'h1000 + i);
    end
    do_cmd(1'b0, 16'hAA02, '0);
    chk(r_hit && r_val == 32'hAA, "R8 new AA02", r_val, 32'hAA);
    do_cmd(1'b0, 16'hBB03, '0);
    chk(r_hit && r_val == 32'hBB, "R8 new BB03", r_val, 32'hBB);
    do_cmd(1'b0, 16'hCC00, '0);
    chk(r_hit && r_val == 32'hCC, "R8 new CC00", r_val, 32'hCC);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    do_reset();
    t_reset_state();
    t_latency();
    t_basic();
    t_collide();
    t_update();
    t_evict();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule